// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block holds calendar time as packed BCD. Seconds, minutes, hours, date, month, a two-digit year and a weekday sit behind a small byte-wide register bus with a 3-bit address. A one-cycle `tick_i` pulse, expected once per second, advances the time. Each counter carries into the next one. The date wraps at the real end of the month, and February gets 29 days in a leap year.

The host loads a field by writing it. A write whose BCD value is malformed or outside the field's range leaves the field unchanged. Bit 7 of the seconds register is a stop flag: while it is set, ticks do nothing, and clearing it resumes from the held time. A control byte with some bits forced and a software flag in the weekday register are also stored. The `YEAR_BASE` parameter gives the calendar year that stored year 00 stands for, and the leap-year rule is taken from it.

Top module: `rtc_bcd_regs`

## Requirements
- R1: Register addresses are 0 control, 1 seconds, 2 minutes, 3 hours, 4 date, 5 month, 6 year and 7 weekday. `rdata_o` is a combinational function of `addr_i` and the stored state.
- R2: After reset, seconds, minutes, hours, year and weekday read 0x00, date and month read 0x01, control reads 0x90, and the stop flag is clear.
- R3: A tick with the stop flag clear and no write in that cycle adds one to the seconds. The carries run seconds 59→00 into minutes, minutes 59→00 into hours, and hours 23→00 into both the date and the weekday. The weekday counts 0 to 6 and then returns to 0; any stored value of 6 or more steps to 0.
- R4: The date wraps to 01 once it has reached the month length, and the month then steps on. Month lengths are 31 days, except 30 for months 4, 6, 9 and 11, and 28 for month 2, or 29 when (YEAR_BASE + year) is divisible by 4. The month wraps from 12 to 01, which steps the year, and the year wraps from 99 to 00.
- R5: A write loads the field in the next cycle. Before the range check, the written byte is masked: seconds and minutes keep bits 6:0, hours and date keep bits 5:0, month keeps bits 4:0, and year keeps all 8 bits. The accepted ranges are seconds and minutes 0–59, hours 0–23, date 1–31, month 1–12 and year 0–99.
- R6: A write is ignored, and the field keeps its value, if the masked value has a nibble above 9 or lies outside the field's range.
- R7: A write to the seconds register always sets the stop flag from bit 7, whether or not the seconds value is accepted. While the flag is set, ticks change nothing. After it is cleared, counting continues from the held value.
- R8: Seconds read as {stop, sec[6:0]}, minutes as {0, min[6:0]}, hours as {00, hr[5:0]}, date as {00, date[5:0]}, month as {000, mon[4:0]}, and year as all 8 bits.
- R9: A weekday write stores bits 2:0 as the weekday and bit 6 as a flag. The weekday register reads {0, flag, 000, weekday}.
- R10: A control write stores (data AND 0x5F) OR 0x90, so bits 7 and 4 read 1 and bit 5 reads 0.
- R11: When a write and a tick fall in the same cycle, the write takes effect and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle time-advance pulse |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |

## Verification
Writes and ticks are registered, so their effect is visible one clock edge after the cycle that carries them. Reads have no latency, and the new value appears as soon as the address settles. The bench drives each stimulus for one edge and drops the strobes two nanoseconds later. It then steps the address across all eight registers, one nanosecond apart, and compares every read with a reference model that it updated for that same edge. A full carry chain, from seconds through to the year, lands on a single edge, so end-of-month, end-of-year and leap-day cases are each checked in the cycle after their one tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0, A_SEC = 3'd1, A_MIN = 3'd2, A_HOUR = 3'd3,
    A_DATE = 3'd4, A_MON = 3'd5, A_YEAR = 3'd6, A_WDAY = 3'd7
  } rtc_addr_e;

  function automatic logic [7:0] bcd2bin(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [7:0] v);
    logic [7:0] t, u;
    t = v / 8'd10;
    u = v % 8'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic bcd_ok(input logic [7:0] b);
    return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    return (b[3:0] == 4'd9) ? {b[7:4] + 4'd1, 4'd0} : {b[7:4], b[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_bcd_cnt.sv
module rtc_bcd_cnt
  import rtc_pkg::*;
#(
  parameter int unsigned LO = 0,
  parameter int unsigned HI = 59
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  input  logic [DW-1:0] roll_max_i,
  output logic [DW-1:0] val_o,
  output logic          wrap_o
);
  localparam logic [7:0] LO_B   = 8'(LO);
  localparam logic [7:0] HI_B   = 8'(HI);
  localparam logic [7:0] LO_BCD = bin2bcd(LO_B);

  logic [7:0] val_q, ld_bin;
  logic       lo_ok, ld_ok;

  assign ld_bin = bcd2bin(ld_val_i);

  generate
    if (LO == 0) begin : g_lo_zero
      assign lo_ok = 1'b1;
    end else begin : g_lo_cmp
      assign lo_ok = ld_bin >= LO_B;
    end
  endgenerate

  assign ld_ok  = bcd_ok(ld_val_i) && lo_ok && (ld_bin <= HI_B);
  // >= so a value loaded past a short month still wraps
  assign wrap_o = inc_i && (bcd2bin(val_q) >= bcd2bin(roll_max_i));
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                val_q <= LO_BCD;
    else if (ld_i && ld_ok)     val_q <= ld_val_i;
    else if (inc_i)             val_q <= wrap_o ? LO_BCD : bcd_inc(val_q);
  end

  // R6: rejected load keeps the value
  p_bad_load_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i && !inc_i && !ld_ok |=> $stable(val_q));
  // R3: wrap returns to the low bound
  p_wrap_to_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o && !ld_i |=> val_q == LO_BCD);
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
#(
  parameter int unsigned YEAR_BASE = 2000
) (
  input  logic [DW-1:0] month_i,
  input  logic [DW-1:0] year_i,
  output logic [DW-1:0] days_o
);
  localparam logic [1:0] LEAP_PHASE = 2'(YEAR_BASE % 4);

  logic [7:0] ybin;
  logic [1:0] ph;
  logic       leap;

  assign ybin = bcd2bin(year_i);
  assign ph   = ybin[1:0] + LEAP_PHASE;
  assign leap = (ph == 2'd0);

  always_comb begin
    unique case (month_i)
      8'h02:                      days_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: days_o = 8'h30;
      default:                    days_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs
  import rtc_pkg::*;
#(
  parameter int unsigned YEAR_BASE = 2000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  // counter index g lives at address g+1: sec, min, hour, date, month, year
  localparam int unsigned NCNT = 6;
  localparam int unsigned IDX_HOUR = 2;
  localparam int unsigned IDX_DATE = 3;
  localparam int unsigned LO_T [NCNT] = '{0, 0, 0, 1, 1, 0};
  localparam int unsigned HI_T [NCNT] = '{59, 59, 23, 31, 12, 99};
  localparam logic [7:0]  MASK_T [NCNT] = '{8'h7F, 8'h7F, 8'h3F, 8'h3F, 8'h1F, 8'hFF};
  localparam logic [7:0]  CTRL_CLR = 8'h5F;
  localparam logic [7:0]  CTRL_SET = 8'h90;

  logic [7:0]      cnt_q [NCNT];
  logic [7:0]      roll  [NCNT];
  logic [NCNT-1:0] inc, wrap;
  logic [7:0]      days;
  logic            stop_q, flag_q, adv;
  logic [2:0]      wday_q;
  logic [7:0]      ctrl_q;

  assign adv = tick_i && !wr_i && !stop_q;

  rtc_month_len #(.YEAR_BASE(YEAR_BASE)) u_mlen (
    .month_i(cnt_q[4]),
    .year_i (cnt_q[5]),
    .days_o (days)
  );

  generate
    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
      if (g == 0) begin : g_first
        assign inc[g] = adv;
      end else begin : g_chain
        assign inc[g] = wrap[g-1];
      end
      if (g == IDX_DATE) begin : g_dyn
        assign roll[g] = days;
      end else begin : g_fix
        assign roll[g] = bin2bcd(8'(HI_T[g]));
      end
      rtc_bcd_cnt #(.LO(LO_T[g]), .HI(HI_T[g])) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .inc_i     (inc[g]),
        .ld_i      (wr_i && (addr_i == 3'(g + 1))),
        .ld_val_i  (wdata_i & MASK_T[g]),
        .roll_max_i(roll[g]),
        .val_o     (cnt_q[g]),
        .wrap_o    (wrap[g])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      flag_q <= 1'b0;
      wday_q <= 3'd0;
      ctrl_q <= CTRL_SET;
    end else begin
      if (wr_i && addr_i == A_SEC)  stop_q <= wdata_i[7];
      if (wr_i && addr_i == A_CTRL) ctrl_q <= (wdata_i & CTRL_CLR) | CTRL_SET;
      if (wr_i && addr_i == A_WDAY) begin
        wday_q <= wdata_i[2:0];
        flag_q <= wdata_i[6];
      end else if (wrap[IDX_HOUR]) begin
        wday_q <= (wday_q >= 3'd6) ? 3'd0 : wday_q + 3'd1;
      end
    end
  end

  always_comb begin
    unique case (rtc_addr_e'(addr_i))
      A_CTRL:  rdata_o = ctrl_q;
      A_SEC:   rdata_o = {stop_q, cnt_q[0][6:0]};
      A_MIN:   rdata_o = {1'b0, cnt_q[1][6:0]};
      A_HOUR:  rdata_o = {2'b0, cnt_q[2][5:0]};
      A_DATE:  rdata_o = {2'b0, cnt_q[3][5:0]};
      A_MON:   rdata_o = {3'b0, cnt_q[4][4:0]};
      A_YEAR:  rdata_o = cnt_q[5];
      A_WDAY:  rdata_o = {1'b0, flag_q, 3'b0, wday_q};
      default: rdata_o = 8'h00;
    endcase
  end

  p_stop_freezes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q && !wr_i |=> $stable(cnt_q[0]));
  p_ctrl_forced_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]);
  p_wr_blocks_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i != A_SEC |=> $stable(cnt_q[0]));
  p_wday_steps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap[IDX_HOUR] |=> wday_q != $past(wday_q));
endmodule

// File: tb/rtc_bcd_regs_bench.sv
module rtc_bcd_regs_bench;
  localparam int BASE = 1970;
  localparam int AC = 0, AS = 1, AMI = 2, AH = 3, AD = 4, AMO = 5, AY = 6, AW = 7;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_sec, m_min, m_hr, m_date, m_mon, m_yr, m_wd, m_flag, m_stop;
  logic [7:0] m_ctrl;

  rtc_bcd_regs #(.YEAR_BASE(BASE)) u_rtc_bcd_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int bin(logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic bit ok(logic [7:0] v, int lo, int hi);
    if (v[7:4] > 4'd9 || v[3:0] > 4'd9) return 1'b0;
    return bin(v) >= lo && bin(v) <= hi;
  endfunction

  function automatic int dim(int m, int y);
    if (m == 2) return ((BASE + y) % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    case (a)
      AC:  return m_ctrl;
      AS:  return {m_stop[0], bcd(m_sec)[6:0]};
      AMI: return bcd(m_min);
      AH:  return bcd(m_hr);
      AD:  return bcd(m_date);
      AMO: return bcd(m_mon);
      AY:  return bcd(m_yr);
      default: return {1'b0, m_flag[0], 3'b000, 3'(m_wd)};
    endcase
  endfunction

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hr = 0; m_yr = 0; m_wd = 0; m_flag = 0; m_stop = 0;
    m_date = 1; m_mon = 1; m_ctrl = 8'h90;
  endtask

  task automatic model_step(bit tk, bit wr, int a, logic [7:0] d);
    logic [7:0] v;
    if (wr) begin
      case (a)
        AC: m_ctrl = (d & 8'h5F) | 8'h90;
        AS: begin m_stop = int'(d[7]); v = d & 8'h7F; if (ok(v, 0, 59)) m_sec = bin(v); end
        AMI: begin v = d & 8'h7F; if (ok(v, 0, 59)) m_min = bin(v); end
        AH: begin v = d & 8'h3F; if (ok(v, 0, 23)) m_hr = bin(v); end
        AD: begin v = d & 8'h3F; if (ok(v, 1, 31)) m_date = bin(v); end
        AMO: begin v = d & 8'h1F; if (ok(v, 1, 12)) m_mon = bin(v); end
        AY: if (ok(d, 0, 99)) m_yr = bin(d);
        default: begin m_wd = int'(d[2:0]); m_flag = int'(d[6]); end
      endcase
    end else if (tk && m_stop == 0) begin
      m_sec++;
      if (m_sec >= 60) begin
        m_sec = 0; m_min++;
        if (m_min >= 60) begin
          m_min = 0; m_hr++;
          if (m_hr >= 24) begin
            m_hr = 0;
            m_wd = (m_wd >= 6) ? 0 : m_wd + 1;
            if (m_date >= dim(m_mon, m_yr)) begin
              m_date = 1;
              if (m_mon >= 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
              else m_mon++;
            end else m_date++;
          end
        end
      end
    end
  endtask

  task automatic verify(string tag);
    for (int a = 0; a < 8; a++) begin
      addr_i = 3'(a);
      #1;
      checks++;
      if (rdata_o !== exp_rd(a)) begin
        errors++;
        $display("FAIL %s addr %0d actual %h expected %h", tag, a, rdata_o, exp_rd(a));
      end
    end
  endtask

  task automatic step(bit tk, bit wr, int a, logic [7:0] d, string tag);
    tick_i = tk; wr_i = wr; addr_i = 3'(a); wdata_i = d;
    @(posedge clk_i);
    model_step(tk, wr, a, d);
    #2;
    tick_i = 1'b0; wr_i = 1'b0;
    verify(tag);
  endtask

  task automatic set_time(int y, int mo, int dt, int h, int mi, int s);
    step(0, 1, AY, bcd(y), "R5");
    step(0, 1, AMO, bcd(mo), "R5");
    step(0, 1, AD, bcd(dt), "R5");
    step(0, 1, AH, bcd(h), "R5");
    step(0, 1, AMI, bcd(mi), "R5");
    step(0, 1, AS, bcd(s), "R5");
  endtask

  function automatic logic [7:0] pick(int a);
    int hi, lo, r;
    logic [7:0] d;
    hi = (a == AS || a == AMI) ? 59 : (a == AH) ? 23 : (a == AD) ? 31 : (a == AMO) ? 12 : 99;
    lo = (a == AD || a == AMO) ? 1 : 0;
    r = int'($urandom % 4);
    if (r == 0) return 8'($urandom);
    d = (r == 1) ? bcd(hi) : (r == 2) ? bcd(lo + int'($urandom % (hi - lo + 1))) : bcd(hi - 1);
    if (a == AS) d[7] = ($urandom % 8 == 0);
    return d;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    model_reset();
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    verify("R2");
    rst_ni = 1'b1;
    @(negedge clk_i);
    verify("R2");

    // R3 plain counting
    for (int i = 0; i < 3; i++) step(1, 0, 0, 8'h00, "R3");
    // R4 year end, R9 weekday with flag
    step(0, 1, AW, 8'h46, "R9");
    set_time(99, 12, 31, 23, 59, 58);
    step(1, 0, 0, 8'h00, "R4");
    step(1, 0, 0, 8'h00, "R4");
    step(0, 1, AW, 8'hBF, "R9");
    step(1, 0, 0, 8'h00, "R3");
    // R6 invalid writes
    step(0, 1, AMI, 8'h60, "R6");
    step(0, 1, AMI, 8'h5A, "R6");
    step(0, 1, AH, 8'h24, "R6");
    step(0, 1, AD, 8'h00, "R6");
    step(0, 1, AD, 8'h32, "R6");
    step(0, 1, AMO, 8'h13, "R6");
    step(0, 1, AMO, 8'h00, "R6");
    step(0, 1, AY, 8'h9A, "R6");
    step(0, 1, AY, 8'hA0, "R6");
    // R7 stop flag set by a rejected seconds write
    step(0, 1, AS, 8'hFA, "R7");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 8'h00, "R7");
    step(0, 1, AS, 8'h10, "R7");
    step(1, 0, 0, 8'h00, "R7");
    step(0, 1, AS, 8'h00, "R7");
    step(1, 0, 0, 8'h00, "R7");
    // R10 control byte
    step(0, 1, AC, 8'hFF, "R10");
    step(0, 1, AC, 8'h00, "R10");
    step(0, 1, AC, 8'h2A, "R10");
    // R8 masking of high bits on writes and reads
    step(0, 1, AMI, 8'hD9, "R8");
    step(0, 1, AH, 8'hE3, "R8");
    step(0, 1, AMO, 8'hF1, "R8");
    step(0, 1, AD, 8'hC5, "R8");
    // R11 write beats tick
    step(1, 1, AMI, 8'h10, "R11");
    step(1, 1, AS, 8'h20, "R11");
    // R4 leap and non-leap February, 30-day month
    set_time(2, 2, 28, 23, 59, 59);
    step(1, 0, 0, 8'h00, "R4");
    set_time(2, 2, 29, 23, 59, 59);
    step(1, 0, 0, 8'h00, "R4");
    set_time(3, 2, 28, 23, 59, 59);
    step(1, 0, 0, 8'h00, "R4");
    set_time(3, 4, 30, 23, 59, 59);
    step(1, 0, 0, 8'h00, "R4");
    set_time(3, 2, 31, 23, 59, 59);
    step(1, 0, 0, 8'h00, "R4");
    // R1 every address round trip through random mix
    for (int it = 0; it < 250; it++) begin
      for (int k = 0; k < 5; k++) begin
        int a;
        a = int'($urandom % 8);
        step(0, 1, a, (a == AC || a == AW) ? 8'($urandom) : pick(a), "R1");
      end
      if ($urandom % 2 == 0) step(0, 1, AS, 8'h58, "R5");
      for (int k = 0; k < 6; k++) begin
        if ($urandom % 7 == 0) begin
          int a;
          a = int'($urandom % 8);
          step(1, 1, a, pick(a), "R11");
        end else begin
          step(1, 0, 0, 8'h00, "R3");
        end
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule